// File: doc/BRIEF.md
# Power-Good Monitor with Deglitch

This block turns a handful of synchronous comparator and fault flags into a single active-high power-good level for a step-down regulator. Two feedback flags set the thresholds. One flag means the feedback sits above the upper ratio of the reference (92.5 %). The other means it sits below the lower ratio (90 %). A further flag reports that the reference itself is above its minimum valid level (0.54 V). Shutdown, supply lockout and thermal trip flags complete the inputs.

A change of the feedback condition reaches the output only after it has held for a programmable number of consecutive clock cycles, 48 by default. The rule is the same for the rising and the falling direction. The gap between the two thresholds gives hysteresis: while neither feedback flag is set, the output keeps its level.

An invalid reference, shutdown, lockout or thermal trip pulls the output low at the next clock edge, with no filtering, and discards any deglitch count in progress. The open-drain pad driver sits outside this block and is fed by `pgood`.

Top module: `pgood_monitor`

## Requirements
- R1: After reset, and from the first clock edge, `pgood` is 0.
- R2: With `ref_valid`=1, no fault flag, `fb_below_fall`=0 and `fb_above_rise`=1 held at DEGLITCH consecutive rising clock edges, `pgood` goes from 0 to 1 right after the DEGLITCH-th edge, and not before.
- R3: With `ref_valid`=1, no fault flag and `fb_below_fall`=1 held at DEGLITCH consecutive edges, `pgood` goes from 1 to 0 right after the DEGLITCH-th edge, and not before.
- R4: If the condition that would move the output lapses before DEGLITCH edges have passed, the count is lost. A later attempt again needs DEGLITCH uninterrupted edges.
- R5: While both feedback flags are 0 (the hysteresis band), `pgood` keeps its level, whether that level is high or low, and the band breaks any deglitch run in progress.
- R6: `ref_valid`=0 forces `pgood` to 0 after the next edge, with no deglitch, and while it stays 0 `pgood` cannot rise.
- R7: Any of `shutdown`, `uv_lockout` or `thermal_trip` at 1 forces `pgood` to 0 after the next edge and clears the deglitch count, so a run cut by a one-cycle fault must restart from zero.
- R8: When both feedback flags are 1 at once, the below-threshold flag wins and the pair is treated as a falling condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_above_rise | input | 1 | Feedback above the upper ratio of the reference |
| fb_below_fall | input | 1 | Feedback below the lower ratio of the reference |
| ref_valid | input | 1 | Reference above its minimum valid level |
| shutdown | input | 1 | Regulator disabled |
| uv_lockout | input | 1 | Supply under the lockout threshold |
| thermal_trip | input | 1 | Thermal shutdown active |
| pgood | output | 1 | Power-good level, 1 = good |

## Verification
The hardest case to reach is a run that stops one cycle short of the deglitch length. Only an exact count shows that the output did not move early, and that the counter was really cleared and did not merely stop. The bench sweeps every pulse length from 1 to DEGLITCH, returning the output to low between pulses with a one-cycle shutdown. It also splits runs of DEGLITCH-1 cycles with a single band cycle or a single fault cycle. In each case the output is sampled exactly one edge before and one edge after the point where it should change.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    AIM_HOLD = 2'd0,
    AIM_LOW  = 2'd1,
    AIM_HIGH = 2'd2
  } aim_t;
endpackage

// File: rtl/pgm_qualify.sv
module pgm_qualify
  import pgm_pkg::*;
(
  input  logic fb_above_rise,
  input  logic fb_below_fall,
  input  logic ref_valid,
  input  logic shutdown,
  input  logic uv_lockout,
  input  logic thermal_trip,
  output logic force_low,
  output aim_t aim
);
  always_comb begin
    force_low = shutdown | uv_lockout | thermal_trip | ~ref_valid;
    // The lower threshold takes priority over the upper one.
    if (fb_below_fall)      aim = AIM_LOW;
    else if (fb_above_rise) aim = AIM_HIGH;
    else                    aim = AIM_HOLD;
  end
endmodule

// File: rtl/pgm_deglitch.sv
module pgm_deglitch
  import pgm_pkg::*;
#(
  parameter int DEGLITCH = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_low,
  input  aim_t aim,
  output logic level
);
  localparam int CW = (DEGLITCH < 2) ? 1 : $clog2(DEGLITCH);
  localparam logic [CW-1:0] LAST = CW'(DEGLITCH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          pending;
  logic          cnt_en, lvl_en;

  always_comb begin
    pending = ((aim == AIM_HIGH) && !lvl_q) || ((aim == AIM_LOW) && lvl_q);
    cnt_d   = cnt_q;
    lvl_d   = lvl_q;
    cnt_en  = 1'b1;
    lvl_en  = 1'b0;
    if (force_low) begin
      cnt_d  = '0;
      lvl_d  = 1'b0;
      lvl_en = 1'b1;
    end else if (pending) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        lvl_d  = ~lvl_q;
        lvl_en = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lvl_en) lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/pgood_monitor.sv
module pgood_monitor
  import pgm_pkg::*;
#(
  parameter int DEGLITCH = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_above_rise,
  input  logic fb_below_fall,
  input  logic ref_valid,
  input  logic shutdown,
  input  logic uv_lockout,
  input  logic thermal_trip,
  output logic pgood
);
  logic force_low;
  aim_t aim;

  pgm_qualify u_qual (
    .fb_above_rise (fb_above_rise),
    .fb_below_fall (fb_below_fall),
    .ref_valid     (ref_valid),
    .shutdown      (shutdown),
    .uv_lockout    (uv_lockout),
    .thermal_trip  (thermal_trip),
    .force_low     (force_low),
    .aim           (aim)
  );

  pgm_deglitch #(.DEGLITCH(DEGLITCH)) u_dg (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_low (force_low),
    .aim       (aim),
    .level     (pgood)
  );
endmodule

// File: rtl/pgood_monitor_chk.sv
module pgood_monitor_chk #(
  parameter int DEGLITCH = 48
) (
  input logic clk,
  input logic rst_n,
  input logic fb_above_rise,
  input logic fb_below_fall,
  input logic ref_valid,
  input logic shutdown,
  input logic uv_lockout,
  input logic thermal_trip,
  input logic pgood
);
  localparam int RW = $clog2(DEGLITCH + 1) + 1;

  logic          fault;
  logic          hi_cond, lo_cond;
  logic [RW-1:0] hi_run, lo_run;

  assign fault   = shutdown | uv_lockout | thermal_trip | ~ref_valid;
  assign hi_cond = !fault && fb_above_rise && !fb_below_fall;
  assign lo_cond = !fault && fb_below_fall;

  // Consecutive-edge run lengths, saturating at DEGLITCH.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      if (!hi_cond) hi_run <= '0;
      else if (hi_run < RW'(DEGLITCH)) hi_run <= hi_run + 1'b1;
      if (!lo_cond) lo_run <= '0;
      else if (lo_run < RW'(DEGLITCH)) lo_run <= lo_run + 1'b1;
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !pgood);

  p_rise_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> (hi_run >= RW'(DEGLITCH)));

  p_fall_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgood) |-> ((lo_run >= RW'(DEGLITCH)) || $past(fault)));

  p_band_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !fb_above_rise && !fb_below_fall) |=> (pgood == $past(pgood)));

  p_ref_forces_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |=> !pgood);

  p_fault_forces_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown || uv_lockout || thermal_trip) |=> !pgood);

  p_both_flags_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_above_rise && fb_below_fall && !pgood) |=> !pgood);
endmodule

bind pgood_monitor pgood_monitor_chk #(.DEGLITCH(DEGLITCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fb_above_rise (fb_above_rise),
  .fb_below_fall (fb_below_fall),
  .ref_valid     (ref_valid),
  .shutdown      (shutdown),
  .uv_lockout    (uv_lockout),
  .thermal_trip  (thermal_trip),
  .pgood         (pgood)
);

// File: tb/sim_pgood_monitor.sv
`timescale 1ns/1ps
module sim_pgood_monitor;
  localparam int DG = 48;

  logic clk = 1'b0;
  logic rst_n;
  logic hi, lo, rv, sd, uv, tt;
  logic pgood;
  int   errors = 0;
  int   checks = 0;

  always #10 clk = ~clk;

  pgood_monitor #(.DEGLITCH(DG)) u0 (
    .clk(clk), .rst_n(rst_n), .fb_above_rise(hi), .fb_below_fall(lo),
    .ref_valid(rv), .shutdown(sd), .uv_lockout(uv), .thermal_trip(tt),
    .pgood(pgood)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (pgood !== exp) begin
      errors++;
      $display("FAIL %s: pgood=%b expected=%b", tag, pgood, exp);
    end
  endtask

  task automatic setin(input logic h, input logic l, input logic r,
                       input logic s, input logic u, input logic t);
    hi = h; lo = l; rv = r; sd = s; uv = u; tt = t;
  endtask

  // One-cycle shutdown, then band: output known low with cleared count.
  task automatic to_low();
    setin(0, 0, 1, 1, 0, 0); step(1);
    setin(0, 0, 1, 0, 0, 0); step(1);
  endtask

  task automatic to_high();
    to_low();
    setin(1, 0, 1, 0, 0, 0); step(DG);
    setin(0, 0, 1, 0, 0, 0); step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: pgood=%b expected=finished", pgood);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    setin(1, 0, 1, 0, 0, 0);
    rst_n = 1'b0;
    step(3);
    chk(1'b0, "R1 in reset");
    rst_n = 1'b1;
    setin(0, 0, 1, 0, 0, 0);
    step(2);
    chk(1'b0, "R1 after reset");

    // R2: exact rise timing
    setin(1, 0, 1, 0, 0, 0); step(DG - 1);
    chk(1'b0, "R2 one edge early");
    step(1);
    chk(1'b1, "R2 rise at DEGLITCH");

    // R5: band holds high
    setin(0, 0, 1, 0, 0, 0); step(3 * DG);
    chk(1'b1, "R5 band holds high");

    // R3: exact fall timing
    setin(0, 1, 1, 0, 0, 0); step(DG - 1);
    chk(1'b1, "R3 one edge early");
    step(1);
    chk(1'b0, "R3 fall at DEGLITCH");

    // R5: band holds low
    setin(0, 0, 1, 0, 0, 0); step(3 * DG);
    chk(1'b0, "R5 band holds low");

    // R4: exhaustive pulse-length sweep for rising
    for (int len = 1; len <= DG; len++) begin
      to_low();
      setin(1, 0, 1, 0, 0, 0); step(len);
      setin(0, 0, 1, 0, 0, 0); step(1);
      chk((len >= DG) ? 1'b1 : 1'b0, "R4 rise pulse sweep");
    end

    // R4/R5: falling run broken by one band cycle restarts
    to_high();
    setin(0, 1, 1, 0, 0, 0); step(DG - 1);
    setin(0, 0, 1, 0, 0, 0); step(1);
    setin(0, 1, 1, 0, 0, 0); step(DG - 1);
    chk(1'b1, "R4 split fall run");
    step(1);
    chk(1'b0, "R4 full fall run");

    // R8: both flags behave as falling
    to_low();
    setin(1, 1, 1, 0, 0, 0); step(2 * DG);
    chk(1'b0, "R8 both flags no rise");
    to_high();
    setin(1, 1, 1, 0, 0, 0); step(DG - 1);
    chk(1'b1, "R8 both flags early");
    step(1);
    chk(1'b0, "R8 both flags fall");

    // R6: invalid reference
    to_high();
    setin(1, 0, 0, 0, 0, 0); step(1);
    chk(1'b0, "R6 immediate low");
    step(2 * DG);
    chk(1'b0, "R6 blocks rise");

    // R7: each fault source, immediate low and count clear
    for (int f = 0; f < 3; f++) begin
      to_high();
      setin(1, 0, 1, f == 0, f == 1, f == 2); step(1);
      chk(1'b0, "R7 fault immediate low");
      to_low();
      setin(1, 0, 1, 0, 0, 0); step(DG - 1);
      setin(1, 0, 1, f == 0, f == 1, f == 2); step(1);
      setin(1, 0, 1, 0, 0, 0); step(DG - 1);
      chk(1'b0, "R7 fault clears count");
      step(1);
      chk(1'b1, "R7 full run after fault");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule